// File: doc/BRIEF.md
# I2C Slave Receiver with Register Control

This block is the target side of an I2C bus for the receive direction. It watches the filtered SCL and SDA lines and finds START, repeated START and STOP conditions. After a START it collects a 7-bit address and a direction bit. It compares the address with a programmable own address and with the all-zero general call address. Software talks to it through four byte-wide registers: control, status, received data and own address.

Each bus event that needs software attention goes through one interrupt flag and one status code. While the flag is raised for an address or a byte, the block holds SCL low. The bus therefore waits until software has read the status and cleared the flag. Software picks ACK or NACK for the next byte ahead of time through an acknowledge-enable bit. An own address with a read direction is acknowledged and handed over to a transmit path through a mode output. That transmit path is not part of this block.

Register map, selected by `reg_addr_i`: 0 = control, 1 = status (read only), 2 = received data (read only), 3 = own address in bits 6:0. Control bits: bit 6 enables the interface, bit 3 is the interrupt flag and bit 2 enables acknowledge. Bits 5, 4 and 0 are stored and read back but have no effect on receive. Bits 7 and 1 read as 0.

Top module: `i2c_tgt_rx`

## Requirements
- R1: After reset, the flag is 0, control reads 0x00, status reads 0xF8, and neither SCL nor SDA is pulled low. Own address reads back from register 3 as written, with bit 7 at 0.
- R2: When enable (control bit 6) and acknowledge-enable (control bit 2) are 1, the own address followed by a write bit (0) does four things: it pulls SDA low for the ninth clock, raises the flag, sets status 0x60, and holds SCL low until the flag is cleared.
- R3: Address 0x00 with a write bit, under the same control settings, is acknowledged with status 0x70.
- R4: A non-matching address, or any address while acknowledge-enable is 0, gets no ACK and raises no flag. Bytes that follow are ignored until the next START.
- R5: A data byte received while addressed with acknowledge-enable 1 is ACKed. It raises the flag with status 0x80, and the byte is readable in register 2 until a later byte replaces it.
- R6: A data byte that completes while acknowledge-enable is 0 is NACKed with status 0x88 and still loaded into register 2. The block then becomes unaddressed: later bytes and the STOP raise no flag.
- R7: A STOP or repeated START while addressed raises the flag with status 0xA0 and does not hold SCL. After a repeated START, address recognition starts again without a STOP.
- R8: The own address with a read bit (1) is ACKed without raising the flag, and `tx_mode_o` is 1 until the next START or STOP.
- R9: Only a control write with bit 3 = 0 clears the flag. A write with bit 3 = 1 neither sets nor clears it. Status reads 0xF8 whenever the flag is 0.
- R10: With enable at 0, the block ignores the bus: no ACK and no flag.
- R11: An SDA pulse shorter than the glitch-filter length while SCL is high is not taken as START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` (combinational) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_low_o | output | 1 | 1 = pull SCL low (clock stretch) |
| sda_low_o | output | 1 | 1 = pull SDA low (acknowledge) |
| irq_o | output | 1 | Interrupt flag |
| tx_mode_o | output | 1 | Read direction handed to the transmit path |

## Verification
The bench sweeps every 7-bit address and expects an ACK only for the own address and address zero. A comparator that was off by one bit, or that ignored the general call, would ACK the wrong target or stay silent.

A run of data bytes ends with acknowledge-enable turned off just before the last byte. A design that sampled that bit at the wrong time would NACK one byte too early or too late, and one that stayed addressed after a NACK would raise a flag on the next byte or on the STOP. Repeated START is checked mid-transfer, because a design that only restarts on STOP would miss the second address. A short SDA dip under a high SCL is injected, because a missing filter would turn it into a false 0xA0 event and a corrupted byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    // Status codes published with the interrupt flag
    localparam logic [7:0] ST_OWN_W     = 8'h60;
    localparam logic [7:0] ST_GCALL     = 8'h70;
    localparam logic [7:0] ST_DATA_ACK  = 8'h80;
    localparam logic [7:0] ST_DATA_NACK = 8'h88;
    localparam logic [7:0] ST_END       = 8'hA0;
    localparam logic [7:0] ST_IDLE      = 8'hF8;

    // Register selects
    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_DATA = 2'd2;
    localparam logic [1:0] RA_OWN  = 2'd3;

    // Control bit positions
    localparam int CB_EN   = 6;
    localparam int CB_FLAG = 3;
    localparam int CB_AA   = 2;
    localparam logic [7:0] CTRL_KEEP = 8'h75;

    localparam int LINES = 2;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_DATA, PH_ACK, PH_XMIT, PH_SKIP
    } phase_e;

    typedef enum logic [1:0] { HIT_NONE, HIT_OWN, HIT_GCALL } hit_e;

    typedef struct packed {
        logic       set;
        logic [7:0] code;
        logic       hold;
        logic       load;
        logic [7:0] data;
    } event_t;

    function automatic hit_e classify(input logic [6:0] rx, input logic [6:0] own);
        if (rx == own)        return HIT_OWN;
        else if (rx == 7'd0)  return HIT_GCALL;
        else                  return HIT_NONE;
    endfunction

    function automatic logic legal_code(input logic [7:0] c);
        return (c == ST_OWN_W) || (c == ST_GCALL) || (c == ST_DATA_ACK) ||
               (c == ST_DATA_NACK) || (c == ST_END);
    endfunction

endpackage

// File: rtl/i2c_tgt_deglitch.sv
module i2c_tgt_deglitch #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);

    logic          s1_q, s2_q, clean_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q    <= 1'b1;
            s2_q    <= 1'b1;
            clean_q <= 1'b1;
            run_q   <= '0;
        end else begin
            s1_q <= raw;
            s2_q <= s1_q;
            if (s2_q == clean_q) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
                clean_q <= s2_q;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign clean = clean_q;

    AST_CLEAN_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (rst)
        !$stable(clean_q) |-> clean_q == $past(s2_q)); // R11

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       ack_en,
    input  logic [6:0] own,
    input  logic       scl,
    input  logic       sda,
    output logic       sda_low,
    output logic       tx_mode,
    output event_t     evt
);
    logic       scl_d, sda_d;
    phase_e     phase_q, after_q;
    logic [3:0] bits_q;
    logic [7:0] shreg_q;
    logic       addressed_q;
    logic       sda_low_q;
    hit_e       hit;

    wire start_c = scl & scl_d & sda_d & ~sda;
    wire stop_c  = scl & scl_d & ~sda_d & sda;
    wire rise_c  = scl & ~scl_d;
    wire fall_c  = ~scl & scl_d;

    assign hit = classify(shreg_q[7:1], own);

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d       <= 1'b1;
            sda_d       <= 1'b1;
            phase_q     <= PH_IDLE;
            after_q     <= PH_IDLE;
            bits_q      <= '0;
            shreg_q     <= '0;
            addressed_q <= 1'b0;
            sda_low_q   <= 1'b0;
            evt         <= '0;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
            evt   <= '0;
            if (!en) begin
                phase_q     <= PH_IDLE;
                addressed_q <= 1'b0;
                sda_low_q   <= 1'b0;
            end else if (start_c || stop_c) begin
                if (addressed_q) begin
                    evt.set  <= 1'b1;
                    evt.code <= ST_END;
                end
                addressed_q <= 1'b0;
                sda_low_q   <= 1'b0;
                bits_q      <= '0;
                phase_q     <= start_c ? PH_ADDR : PH_IDLE;
            end else begin
                unique case (phase_q)
                    PH_ADDR, PH_DATA: begin
                        if (rise_c) begin
                            shreg_q <= {shreg_q[6:0], sda};
                            bits_q  <= bits_q + 4'd1;
                        end else if (fall_c && bits_q == 4'd8) begin
                            bits_q <= '0;
                            if (phase_q == PH_ADDR) begin
                                if (ack_en && !shreg_q[0] && hit != HIT_NONE) begin
                                    evt.set     <= 1'b1;
                                    evt.hold    <= 1'b1;
                                    evt.code    <= (hit == HIT_OWN) ? ST_OWN_W : ST_GCALL;
                                    sda_low_q   <= 1'b1;
                                    addressed_q <= 1'b1;
                                    after_q     <= PH_DATA;
                                    phase_q     <= PH_ACK;
                                end else if (ack_en && shreg_q[0] && hit == HIT_OWN) begin
                                    sda_low_q <= 1'b1;
                                    after_q   <= PH_XMIT;
                                    phase_q   <= PH_ACK;
                                end else begin
                                    phase_q <= PH_SKIP;
                                end
                            end else begin
                                evt.set   <= 1'b1;
                                evt.hold  <= 1'b1;
                                evt.load  <= 1'b1;
                                evt.data  <= shreg_q;
                                evt.code  <= ack_en ? ST_DATA_ACK : ST_DATA_NACK;
                                sda_low_q <= ack_en;
                                after_q   <= ack_en ? PH_DATA : PH_SKIP;
                                phase_q   <= PH_ACK;
                                if (!ack_en) addressed_q <= 1'b0;
                            end
                        end
                    end
                    PH_ACK: begin
                        if (fall_c) begin
                            sda_low_q <= 1'b0;
                            phase_q   <= after_q;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_low = sda_low_q;
    assign tx_mode = (phase_q == PH_XMIT);

    AST_ACK_ON_LOW_SCL: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_low_q) |-> !$past(scl)); // R2
    AST_EVENT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        evt.set |-> $past(en)); // R10
    AST_EVENT_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        evt.set |-> legal_code(evt.code)); // R5
    AST_XMIT_NOT_RX: assert property (@(posedge clk) disable iff (rst)
        tx_mode |-> !addressed_q); // R8

endmodule

// File: rtl/i2c_tgt_rx.sv
module i2c_tgt_rx
    import i2c_tgt_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_we_i,
    input  logic [1:0] reg_addr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_low_o,
    output logic       sda_low_o,
    output logic       irq_o,
    output logic       tx_mode_o
);
    logic [LINES-1:0] raw_bus, clean_bus;
    logic [7:0]       ctrl_q, stat_q, data_q;
    logic [6:0]       own_q;
    logic             flag_q, hold_q;
    event_t           evt;

    assign raw_bus = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        i2c_tgt_deglitch #(.FILT_LEN(FILT_LEN)) u_dg (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw_bus[g]),
            .clean (clean_bus[g])
        );
    end

    i2c_tgt_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_q[CB_EN]),
        .ack_en  (ctrl_q[CB_AA]),
        .own     (own_q),
        .scl     (clean_bus[1]),
        .sda     (clean_bus[0]),
        .sda_low (sda_low_o),
        .tx_mode (tx_mode_o),
        .evt     (evt)
    );

    wire ctrl_wr = reg_we_i && (reg_addr_i == RA_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            own_q  <= '0;
            flag_q <= 1'b0;
            hold_q <= 1'b0;
            stat_q <= ST_IDLE;
            data_q <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= reg_wdata_i & CTRL_KEEP;
                if (!reg_wdata_i[CB_FLAG]) flag_q <= 1'b0;
            end
            if (reg_we_i && reg_addr_i == RA_OWN) own_q <= reg_wdata_i[6:0];
            if (evt.set) begin
                flag_q <= 1'b1;
                hold_q <= evt.hold;
                stat_q <= evt.code;
            end
            if (evt.load) data_q <= evt.data;
        end
    end

    always_comb begin
        unique case (reg_addr_i)
            RA_CTRL: reg_rdata_o = ctrl_q | {4'd0, flag_q, 3'd0};
            RA_STAT: reg_rdata_o = flag_q ? stat_q : ST_IDLE;
            RA_DATA: reg_rdata_o = data_q;
            default: reg_rdata_o = {1'b0, own_q};
        endcase
    end

    assign scl_low_o = flag_q & hold_q;
    assign irq_o     = flag_q;

    AST_FLAG_CLEARED_BY_SW: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q) |-> $past(ctrl_wr && !reg_wdata_i[CB_FLAG])); // R9
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_q) |-> flag_q); // R5
    AST_END_NO_STRETCH: assert property (@(posedge clk) disable iff (rst)
        (flag_q && stat_q == ST_END) |-> !scl_low_o); // R7

endmodule

// File: tb/i2c_tgt_rx_bench.sv
`timescale 1ns/1ps
module i2c_tgt_rx_bench;
    localparam int H = 16;
    localparam logic [6:0] OWN = 7'h2B;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we = 1'b0;
    logic [1:0] ra = 2'd0;
    logic [7:0] wd = 8'd0;
    logic [7:0] rd;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_low, sda_low, irq, txm;
    logic       scl_ln, sda_ln;
    logic       en_b = 1'b0, ack_b = 1'b0;
    logic       done = 1'b0;
    int         checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    assign scl_ln = scl_m & ~scl_low;
    assign sda_ln = sda_m & ~sda_low;

    i2c_tgt_rx u_i2c_tgt_rx (
        .clk(clk), .rst(rst), .reg_we_i(we), .reg_addr_i(ra), .reg_wdata_i(wd),
        .reg_rdata_o(rd), .scl_i(scl_ln), .sda_i(sda_ln), .scl_low_o(scl_low),
        .sda_low_o(sda_low), .irq_o(irq), .tx_mode_o(txm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rreg(input logic [1:0] a, output logic [7:0] d);
        ra = a;
        #1;
        d = rd;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; ra = a; wd = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    function automatic logic [7:0] cv(input logic e, input logic a);
        return {1'b0, e, 3'b000, a, 2'b00};
    endfunction

    task automatic clear_flag();
        wreg(2'd0, cv(en_b, ack_b));
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1;
        while (!scl_ln) tick(1);
        tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic send_bit(input logic b, input logic glitch);
        sda_m = b; tick(H);
        scl_m = 1'b1;
        while (!scl_ln) tick(1);
        if (glitch) begin
            tick(4); sda_m = ~b; tick(2); sda_m = b; tick(H - 6);
        end else begin
            tick(H);
        end
        scl_m = 1'b0; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic glitch, input string req,
                             output logic ack, output logic flag, output logic [7:0] st);
        for (int i = 7; i >= 0; i--) send_bit(b[i], glitch && i == 7);
        tick(H);
        flag = irq;
        rreg(2'd1, st);
        sda_m = 1'b1; scl_m = 1'b1; tick(H);
        if (flag) begin
            chk({req, " SCL held while flag set"}, scl_ln, 1'b0);
            clear_flag();
        end
        while (!scl_ln) tick(1);
        tick(H / 2);
        ack = ~sda_ln;
        tick(H / 2);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic end_check(input logic exp_flag, input string req);
        logic [7:0] st;
        tick(H);
        chk({req, " flag after end condition"}, irq, exp_flag);
        if (exp_flag) begin
            rreg(2'd1, st);
            chk({req, " end status"}, st, 8'hA0);
            chk({req, " no stretch on end"}, scl_low, 1'b0);
            clear_flag();
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic       ack, flag;
        logic [7:0] st, d;

        tick(5);
        rst = 1'b0;
        tick(2);

        // R1: reset state
        chk("R1 irq", irq, 1'b0);
        chk("R1 scl release", scl_low, 1'b0);
        chk("R1 sda release", sda_low, 1'b0);
        chk("R1 tx mode", txm, 1'b0);
        rreg(2'd0, d); chk("R1 control", d, 8'h00);
        rreg(2'd1, d); chk("R1 status", d, 8'hF8);
        wreg(2'd3, {1'b1, OWN});
        rreg(2'd3, d); chk("R1 own address readback", d, {1'b0, OWN});

        // R10: disabled interface ignores its own address
        en_b = 1'b0; ack_b = 1'b1; wreg(2'd0, cv(en_b, ack_b));
        bus_start();
        send_byte({OWN, 1'b0}, 1'b0, "R10", ack, flag, st);
        chk("R10 no ack when disabled", ack, 1'b0);
        chk("R10 no flag when disabled", flag, 1'b0);
        bus_stop();
        end_check(1'b0, "R10");

        // R2 R3 R4: full address sweep, write direction
        en_b = 1'b1; wreg(2'd0, cv(en_b, ack_b));
        for (int a = 0; a < 128; a++) begin
            logic hit;
            string req;
            hit = (a == OWN) || (a == 0);
            req = (a == OWN) ? "R2" : ((a == 0) ? "R3" : "R4");
            bus_start();
            send_byte({a[6:0], 1'b0}, 1'b0, req, ack, flag, st);
            chk({req, " ack on address"}, ack, hit);
            chk({req, " flag on address"}, flag, hit);
            if (hit) chk({req, " address status"}, st, (a == 0) ? 8'h70 : 8'h60);
            bus_stop();
            end_check(hit, "R7");
        end

        // R4: acknowledge disabled
        ack_b = 1'b0; wreg(2'd0, cv(en_b, ack_b));
        bus_start();
        send_byte({OWN, 1'b0}, 1'b0, "R4", ack, flag, st);
        chk("R4 no ack with ack-enable 0", ack, 1'b0);
        chk("R4 no flag with ack-enable 0", flag, 1'b0);
        bus_stop();
        end_check(1'b0, "R4");
        ack_b = 1'b1; wreg(2'd0, cv(en_b, ack_b));

        // R4: bytes after a missed address are ignored until START
        bus_start();
        send_byte({7'h55, 1'b0}, 1'b0, "R4", ack, flag, st);
        chk("R4 foreign address not acked", ack, 1'b0);
        send_byte({OWN, 1'b0}, 1'b0, "R4", ack, flag, st);
        chk("R4 own address without START ignored", ack, 1'b0);
        chk("R4 no flag without START", flag, 1'b0);
        bus_stop();
        end_check(1'b0, "R4");

        // R5 R6: data run, ack-enable dropped for the last byte
        bus_start();
        send_byte({OWN, 1'b0}, 1'b0, "R2", ack, flag, st);
        chk("R2 ack before data run", ack, 1'b1);
        for (int i = 0; i < 12; i++) begin
            logic [7:0] v;
            logic       last;
            v = 8'((i * 73 + 19) & 255);
            last = (i == 11);
            if (i == 10) ack_b = 1'b0;
            send_byte(v, 1'b0, last ? "R6" : "R5", ack, flag, st);
            chk(last ? "R6 nack on byte" : "R5 ack on byte", ack, !last);
            chk(last ? "R6 flag" : "R5 flag", flag, 1'b1);
            chk(last ? "R6 status" : "R5 status", st, last ? 8'h88 : 8'h80);
            rreg(2'd2, d);
            chk(last ? "R6 data register" : "R5 data register", d, v);
        end
        send_byte(8'h3C, 1'b0, "R6", ack, flag, st);
        chk("R6 byte after nack not acked", ack, 1'b0);
        chk("R6 byte after nack raises no flag", flag, 1'b0);
        rreg(2'd2, d);
        chk("R6 data register unchanged", d, 8'((11 * 73 + 19) & 255));
        bus_stop();
        end_check(1'b0, "R6");
        ack_b = 1'b1; wreg(2'd0, cv(en_b, ack_b));

        // R7 R9: repeated START mid-transfer
        bus_start();
        send_byte({OWN, 1'b0}, 1'b0, "R7", ack, flag, st);
        send_byte(8'h11, 1'b0, "R7", ack, flag, st);
        chk("R7 byte before restart acked", ack, 1'b1);
        bus_rstart();
        tick(H);
        chk("R7 flag on repeated START", irq, 1'b1);
        rreg(2'd1, d); chk("R7 status on repeated START", d, 8'hA0);
        chk("R7 no stretch on repeated START", scl_low, 1'b0);
        wreg(2'd0, cv(en_b, ack_b) | 8'h08);
        tick(2);
        chk("R9 writing flag bit 1 keeps flag", irq, 1'b1);
        clear_flag();
        tick(2);
        chk("R9 writing flag bit 0 clears flag", irq, 1'b0);
        send_byte({OWN, 1'b0}, 1'b0, "R7", ack, flag, st);
        chk("R7 address after restart acked", ack, 1'b1);
        chk("R7 address after restart status", st, 8'h60);
        bus_stop();
        end_check(1'b1, "R7");

        // R8: read direction hand-off
        bus_start();
        send_byte({OWN, 1'b1}, 1'b0, "R8", ack, flag, st);
        chk("R8 read address acked", ack, 1'b1);
        chk("R8 read address raises no flag", flag, 1'b0);
        chk("R8 transmit mode on", txm, 1'b1);
        bus_stop();
        tick(H);
        chk("R8 transmit mode off after STOP", txm, 1'b0);
        chk("R8 no flag after STOP", irq, 1'b0);

        // R9: writing 1 to the flag bit does not set it
        wreg(2'd0, cv(en_b, ack_b) | 8'h08);
        tick(2);
        chk("R9 flag not set by software", irq, 1'b0);
        rreg(2'd1, d); chk("R9 status idle code", d, 8'hF8);
        rreg(2'd0, d); chk("R9 control readback", d, cv(en_b, ack_b));

        // R11: short SDA dip under high SCL
        bus_start();
        send_byte({OWN, 1'b0}, 1'b0, "R11", ack, flag, st);
        send_byte(8'hC5, 1'b1, "R11", ack, flag, st);
        chk("R11 glitched byte acked", ack, 1'b1);
        chk("R11 glitched byte status", st, 8'h80);
        rreg(2'd2, d); chk("R11 glitched byte data", d, 8'hC5);
        bus_stop();
        end_check(1'b1, "R11");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule